// File: doc/BRIEF.md
# SOF-Referenced Oscillator Trim Calibrator

This block closes a frequency-trim loop around an on-chip free-running oscillator. Its reference is the host-timed start-of-frame (SOF) marker of a full-speed USB link, nominally 1 ms apart. The block runs in the oscillator clock domain. It counts oscillator cycles between two consecutive SOF pulses and compares that count with a programmed target (for example 96000 for 96 MHz). It then moves an 8-bit trim code by one step toward the target. Each trim step shifts the frequency by about 0.1 %. The code-to-frequency curve is non-linear and varies between dies, so the block converges by repeated measure-and-nudge steps rather than by computing a code. The loop can start up to ±1 % off and must end inside the ±0.25 % that full-speed USB tolerates.

The acceptance band around the target is `target_count >> TOL_SHIFT` on each side. The default shift of 9 gives about ±0.2 %. An interval shorter than half the target or longer than one and a half times the target is treated as a missed or spurious SOF. Such an interval is dropped and flagged. After every trim change, the next interval is discarded so that the oscillator can settle.

The control state machine has four states. IDLE holds while enable is low. IDLE goes to ARM when enable rises. ARM goes to MEASURE on the first completed SOF, which only starts the count. In MEASURE, an interval that changes the trim goes to SETTLE; every other interval stays in MEASURE. SETTLE goes back to MEASURE on the next interval, which it discards. From every state, enable low returns to IDLE.

Top module: `osc_trim_cal`

## Requirements
- R1: In reset, `trim_code` equals TRIM_INIT (default 128), and `locked` and `frame_err` are 0.
- R2: The measured interval is the number of clock cycles between two consecutive sampled SOF pulses while enabled. The first SOF after enable only starts counting and yields no result. A result updates the outputs on the second rising edge after the SOF is sampled.
- R3: An interval above `target + tol` lowers the trim by 1. An interval below `target - tol` raises it by 1. An interval inside `[target - tol, target + tol]`, bounds included, leaves the trim unchanged. Here `tol = target_count >> TOL_SHIFT`.
- R4: The trim saturates at 0 and at 255 and never wraps. A correction that would pass a limit changes nothing and starts no settle slot.
- R5: An interval below `target >> 1` or above `target + (target >> 1)` is discarded and leaves the trim unchanged. It produces a single-cycle `frame_err` pulse.
- R6: The interval that follows a trim change is ignored for trim and lock purposes. If that interval is out of range, it still pulses `frame_err`.
- R7: `locked` rises after 4 consecutive in-band intervals. It falls on the first out-of-band or out-of-range interval.
- R8: With `enable` low, SOF pulses are ignored, `locked` is 0 and `trim_code` holds its value. When `enable` returns, the block re-arms as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the calibration loop when high |
| sof_pulse | input | 1 | Synchronised single-cycle start-of-frame marker |
| target_count | input | CNT_W | Expected oscillator cycles per frame |
| trim_code | output | TRIM_W | Oscillator frequency-trim code |
| locked | output | 1 | Frequency held in band for the required run of frames |
| frame_err | output | 1 | One-cycle pulse for a discarded out-of-range interval |

## Verification
The settle-slot discard and the out-of-range detector can act on the same interval. This happens when a spurious or missed SOF lands just after a trim step. The bench provokes it with an out-of-band frame that moves the trim, followed directly by a far-too-short frame. It judges that `frame_err` still pulses while the trim and lock state stay exactly as the discard rule requires. A near-exhaustive sweep of interval lengths across both band edges and both range edges runs from a clean measuring state. Long runs toward each trim limit then confirm saturation.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_MEASURE,
        ST_SETTLE
    } cal_state_e;

    typedef enum logic [1:0] {
        CLS_IN,
        CLS_LOW,
        CLS_HIGH,
        CLS_BAD
    } frame_class_e;

endpackage

// File: rtl/osc_frame_counter.sv
module osc_frame_counter #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             sof_pulse,
    output logic [CNT_W-1:0] meas_count,
    output logic             meas_vld
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt    <= '0;
            meas_count <= '0;
            meas_vld   <= 1'b0;
        end else if (!enable) begin
            run_cnt  <= '0;
            meas_vld <= 1'b0;
        end else if (sof_pulse) begin
            meas_count <= run_cnt;
            meas_vld   <= 1'b1;
            run_cnt    <= CNT_W'(1);
        end else begin
            meas_vld <= 1'b0;
            if (run_cnt != CNT_MAX)
                run_cnt <= run_cnt + CNT_W'(1);
        end
    end

    // R2
    result_follows_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_vld |-> $past(sof_pulse && enable));

endmodule

// File: rtl/osc_frame_classifier.sv
module osc_frame_classifier
    import osc_trim_pkg::*;
#(
    parameter int CNT_W     = 18,
    parameter int TOL_SHIFT = 9
) (
    input  logic [CNT_W-1:0] meas_count,
    input  logic [CNT_W-1:0] target_count,
    output frame_class_e     frame_cls
);
    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] meas_x, tgt_x, tol_x, half_x;
    logic [EXT_W-1:0] band_hi, band_lo, range_hi;

    always_comb begin
        meas_x   = EXT_W'(meas_count);
        tgt_x    = EXT_W'(target_count);
        tol_x    = tgt_x >> TOL_SHIFT;
        half_x   = tgt_x >> 1;
        band_hi  = tgt_x + tol_x;
        band_lo  = tgt_x - tol_x;
        range_hi = tgt_x + half_x;

        if (meas_x < half_x || meas_x > range_hi)
            frame_cls = CLS_BAD;
        else if (meas_x > band_hi)
            frame_cls = CLS_HIGH;
        else if (meas_x < band_lo)
            frame_cls = CLS_LOW;
        else
            frame_cls = CLS_IN;
    end

endmodule

// File: rtl/osc_trim_fsm.sv
module osc_trim_fsm
    import osc_trim_pkg::*;
#(
    parameter int TRIM_W      = 8,
    parameter int TRIM_INIT   = 128,
    parameter int LOCK_FRAMES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              meas_vld,
    input  frame_class_e      frame_cls,
    output logic [TRIM_W-1:0] trim_q,
    output logic              locked_q,
    output logic              frame_err_q
);
    localparam int                RUN_W    = $clog2(LOCK_FRAMES + 1);
    localparam logic [TRIM_W-1:0] TRIM_MAX = '1;
    localparam logic [RUN_W-1:0]  RUN_FULL = RUN_W'(LOCK_FRAMES);
    localparam logic [RUN_W-1:0]  RUN_LAST = RUN_W'(LOCK_FRAMES - 1);

    cal_state_e        state_q, state_d;
    logic [TRIM_W-1:0] trim_d;
    logic [RUN_W-1:0]  run_q, run_d;
    logic              lock_d, err_d;

    always_comb begin
        state_d = state_q;
        trim_d  = trim_q;
        run_d   = run_q;
        lock_d  = locked_q;
        err_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (enable) state_d = ST_ARM;
            end
            ST_ARM: begin
                if (meas_vld) state_d = ST_MEASURE;
            end
            ST_MEASURE: begin
                if (meas_vld) begin
                    unique case (frame_cls)
                        CLS_BAD: begin
                            err_d  = 1'b1;
                            run_d  = '0;
                            lock_d = 1'b0;
                        end
                        CLS_HIGH: begin
                            run_d  = '0;
                            lock_d = 1'b0;
                            if (trim_q != '0) begin
                                trim_d  = trim_q - TRIM_W'(1);
                                state_d = ST_SETTLE;
                            end
                        end
                        CLS_LOW: begin
                            run_d  = '0;
                            lock_d = 1'b0;
                            if (trim_q != TRIM_MAX) begin
                                trim_d  = trim_q + TRIM_W'(1);
                                state_d = ST_SETTLE;
                            end
                        end
                        CLS_IN: begin
                            if (run_q != RUN_FULL) run_d = run_q + RUN_W'(1);
                            if (run_q >= RUN_LAST) lock_d = 1'b1;
                        end
                    endcase
                end
            end
            ST_SETTLE: begin
                if (meas_vld) begin
                    state_d = ST_MEASURE;
                    if (frame_cls == CLS_BAD) err_d = 1'b1;
                end
            end
        endcase
        if (!enable) begin
            state_d = ST_IDLE;
            run_d   = '0;
            lock_d  = 1'b0;
            err_d   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trim_q      <= TRIM_W'(TRIM_INIT);
            run_q       <= '0;
            locked_q    <= 1'b0;
            frame_err_q <= 1'b0;
        end else begin
            trim_q      <= trim_d;
            run_q       <= run_d;
            locked_q    <= lock_d;
            frame_err_q <= err_d;
        end
    end

    // R3
    trim_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_q != $past(trim_q)) |->
        ((trim_q - $past(trim_q) == TRIM_W'(1)) || ($past(trim_q) - trim_q == TRIM_W'(1))));

    // R5
    err_keeps_trim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_q |-> $stable(trim_q));

    // R6
    settle_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && meas_vld) |=> ($stable(trim_q) && !locked_q));

    // R7
    lock_in_measure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |-> (state_q == ST_MEASURE));

    // R8
    lock_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !locked_q);

endmodule

// File: rtl/osc_trim_cal.sv
module osc_trim_cal
    import osc_trim_pkg::*;
#(
    parameter int CNT_W       = 18,
    parameter int TRIM_W      = 8,
    parameter int TOL_SHIFT   = 9,
    parameter int LOCK_FRAMES = 4,
    parameter int TRIM_INIT   = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              sof_pulse,
    input  logic [CNT_W-1:0]  target_count,
    output logic [TRIM_W-1:0] trim_code,
    output logic              locked,
    output logic              frame_err
);
    logic [CNT_W-1:0] meas_count;
    logic             meas_vld;
    frame_class_e     frame_cls;

    osc_frame_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .sof_pulse  (sof_pulse),
        .meas_count (meas_count),
        .meas_vld   (meas_vld)
    );

    osc_frame_classifier #(.CNT_W(CNT_W), .TOL_SHIFT(TOL_SHIFT)) u_classify (
        .meas_count   (meas_count),
        .target_count (target_count),
        .frame_cls    (frame_cls)
    );

    osc_trim_fsm #(
        .TRIM_W      (TRIM_W),
        .TRIM_INIT   (TRIM_INIT),
        .LOCK_FRAMES (LOCK_FRAMES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .meas_vld    (meas_vld),
        .frame_cls   (frame_cls),
        .trim_q      (trim_code),
        .locked_q    (locked),
        .frame_err_q (frame_err)
    );

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!locked && !frame_err);
        end
    end

endmodule

// File: tb/osc_trim_cal_tb.sv
module osc_trim_cal_tb;
    localparam int CNT_W  = 18;
    localparam int TGT    = 64;
    localparam int TSHIFT = 3;
    localparam int TOL    = TGT >> TSHIFT;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             sof_pulse = 1'b0;
    logic [CNT_W-1:0] target_count = CNT_W'(TGT);
    logic [7:0]       trim_code;
    logic             locked, frame_err;

    int checks = 0, errors = 0;
    int m_trim = 128, m_run = 0;
    bit m_en = 0, m_armed = 0, m_settle = 0, m_locked = 0, m_err = 0;
    bit err_seen = 0;
    int pend_iv = 0;
    string m_tag;

    always #10 clk = ~clk;

    osc_trim_cal #(.CNT_W(CNT_W), .TOL_SHIFT(TSHIFT)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sof_pulse(sof_pulse),
        .target_count(target_count), .trim_code(trim_code),
        .locked(locked), .frame_err(frame_err)
    );

    always @(negedge clk) if (frame_err) err_seen = 1'b1;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_frame(int iv);
        bit bad, hi, lo;
        m_err = 0;
        m_tag = "R8";
        if (!m_en) return;
        if (!m_armed) begin
            m_armed = 1; m_tag = "R2"; return;
        end
        bad = (iv < TGT / 2) || (iv > TGT + TGT / 2);
        hi  = iv > TGT + TOL;
        lo  = iv < TGT - TOL;
        if (m_settle) begin
            m_settle = 0; m_err = bad; m_tag = "R6"; return;
        end
        if (bad) begin
            m_err = 1; m_run = 0; m_locked = 0; m_tag = "R5";
        end else if (hi) begin
            m_run = 0; m_locked = 0;
            if (m_trim > 0) begin m_trim--; m_settle = 1; m_tag = "R3"; end
            else m_tag = "R4";
        end else if (lo) begin
            m_run = 0; m_locked = 0;
            if (m_trim < 255) begin m_trim++; m_settle = 1; m_tag = "R3"; end
            else m_tag = "R4";
        end else begin
            if (m_run < 4) m_run++;
            m_locked = (m_run >= 4);
            m_tag = "R7";
        end
    endtask

    task automatic pulse(int gap);
        err_seen = 0;
        sof_pulse = 1'b1;
        @(negedge clk);
        sof_pulse = 1'b0;
        repeat (gap - 1) @(negedge clk);
        model_frame(pend_iv);
        if (m_en) pend_iv = gap;
        chk({m_tag, " trim"}, trim_code, m_trim);
        chk({m_tag, " locked"}, locked, m_locked);
        chk({m_tag, " frame_err"}, err_seen, m_err);
    endtask

    task automatic set_enable(bit v);
        enable = v;
        repeat (3) @(negedge clk);
        m_en = v;
        m_armed = 0; m_settle = 0; m_run = 0; m_locked = 0;
        chk("R8 locked after enable change", locked, 0);
        chk("R8 trim held", trim_code, m_trim);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 trim reset", trim_code, 128);
        chk("R1 locked reset", locked, 0);
        chk("R1 frame_err reset", frame_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        set_enable(1);
        // R2: arming pulse, then a lock run (R7)
        for (int i = 0; i < 6; i++) pulse(TGT);
        // R3/R5 boundary sweep, each interval measured from a clean state
        for (int g = 25; g <= 105; g++) begin
            pulse(g);
            pulse(TGT);
            pulse(TGT);
            pulse(TGT);
        end
        // R6 with R5: a bad frame lands in the settle slot
        pulse(TGT);
        pulse(80);
        pulse(20);
        pulse(TGT);
        pulse(TGT);
        // R4: drive the trim to its upper limit, then to its lower limit
        for (int i = 0; i < 270; i++) pulse(50);
        chk("R4 upper saturation", trim_code, 255);
        for (int i = 0; i < 530; i++) pulse(80);
        chk("R4 lower saturation", trim_code, 0);
        // R8: disable while locked, SOFs ignored, re-arm on enable
        for (int i = 0; i < 6; i++) pulse(TGT);
        set_enable(0);
        pulse(20);
        pulse(20);
        set_enable(1);
        pulse(20);
        pulse(TGT);
        pulse(TGT);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule